// File: doc/BRIEF.md
# Multi-Ratio Gated Clock Output Generator

This block produces three clock outputs from two free-running clock inputs. Output A runs from the secondary clock. Outputs B and C run from the primary clock, which is nominally 33.8688 MHz and may come from an oscillator or from an external source. Each output takes its own ratio code from a small control register. That register is written through a one-cycle write strobe in the primary clock domain.

Each output channel accepts only a set of ratios that belongs to that channel. The ratios are pass-through, divide-by-2, divide-by-5, divide-by-512, a two-of-five pulse train, and stopped. A code outside a channel's set parks that channel in the stopped state.

A channel moves from one ratio to another only while its output is low, so a ratio change never produces a shortened pulse. Pass-through is made by gating the input clock with an enable that changes on the falling edge. Every divided rate comes from a register clocked on the rising edge.

Top module: `mclk_gen`

## Requirements
- R1: While reset is held and after reset is released, with no write yet made, all three outputs stay low. Every channel is stopped and every control field reads as code 0.
- R2: A write strobe loads the 9-bit control word in one primary clock cycle. Bits [2:0] select the ratio of output A, bits [5:3] that of output B and bits [8:6] that of output C. The code values are: 0 stopped, 1 pass-through, 2 divide-by-2, 3 divide-by-5, 4 two-of-five, 5 divide-by-512. Codes 6 and 7 are unused.
- R3: Output A accepts codes 0, 1 and 2. Code 1 reproduces the secondary clock. Code 2 gives a wave that is high for one secondary cycle and low for the next.
- R4: Output B accepts codes 0, 1, 2, 3 and 5. Code 1 reproduces the primary clock and code 2 halves it.
- R5: Output C accepts codes 0, 1, 3, 4 and 5. Code 1 reproduces the primary clock.
- R6: Divide-by-5, on B or C, repeats every 5 input cycles and is high for 2 of those cycles. Its duty cycle is therefore within one input cycle of half.
- R7: The two-of-five rate on C repeats every 5 primary cycles in the order high, low, high, low, low. This gives two pulses per five input cycles.
- R8: Divide-by-512, on B or C, is high for 256 input cycles and then low for 256.
- R9: A code outside a channel's accepted set (6 and 7 for every channel, 3 to 5 for A, 4 for B, 2 for C) puts that channel in the stopped state, and its output holds low.
- R10: A ratio change is taken up only while the output is low. No high or low phase of any output is ever shorter than half a period of its input clock.
- R11: Code 0 stops the channel, and its output holds low for as long as the code stays.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary clock, source of outputs B and C and of the control register |
| clk_sec | input | 1 | Secondary clock, source of output A |
| rst | input | 1 | Synchronous active-high reset, held across cycles of both clocks |
| wr_en | input | 1 | Control register write strobe (primary domain) |
| wr_data | input | 9 | Control word: A in [2:0], B in [5:3], C in [8:6] |
| mclk_a | output | 1 | Clock output A |
| mclk_b | output | 1 | Clock output B |
| mclk_c | output | 1 | Clock output C |

## Verification
The assertions check four things on every cycle. The ratio a channel runs at changes only when the divided wave was low in the cycle before. No channel ever runs a ratio outside its accepted set. The divided wave stays low while a channel is stopped or in pass-through. Divide-by-5 and two-of-five keep the shapes of their high phases. The exact waveforms that appear at the pins (the pass-through clock pattern, the whole period of each divider, and the code mapping to the stopped state), together with the minimum phase widths measured across every switch, can be shown only by the bench's sweep of every code on every channel.

// File: rtl/mclk_pkg.sv
package mclk_pkg;

    localparam int SEL_W    = 3;
    localparam int NUM_CH   = 3;
    localparam int CTRL_W   = SEL_W * NUM_CH;

    typedef enum logic [SEL_W-1:0] {
        RS_STOP  = 3'd0,
        RS_FULL  = 3'd1,
        RS_HALF  = 3'd2,
        RS_FIFTH = 3'd3,
        RS_TWO5  = 3'd4,
        RS_SLOW  = 3'd5
    } ratio_e;

    // Accepted-code masks, one bit per code value
    localparam logic [7:0] MASK_A = 8'b0000_0111;
    localparam logic [7:0] MASK_B = 8'b0010_1111;
    localparam logic [7:0] MASK_C = 8'b0011_1011;

    function automatic ratio_e decode_sel(input logic [SEL_W-1:0] code,
                                          input logic [7:0] mask);
        if (mask[code]) return ratio_e'(code);
        return RS_STOP;
    endfunction

    function automatic int ratio_period(input ratio_e r, input int slow_div);
        case (r)
            RS_HALF:  return 2;
            RS_FIFTH: return 5;
            RS_TWO5:  return 5;
            RS_SLOW:  return slow_div;
            default:  return 1;
        endcase
    endfunction

    // Level of the divided wave in phase slot ph of the period
    function automatic logic ratio_level(input ratio_e r, input int ph,
                                         input int slow_div);
        case (r)
            RS_HALF:  return ph == 0;
            RS_FIFTH: return ph < 2;
            RS_TWO5:  return (ph == 0) || (ph == 2);
            RS_SLOW:  return ph < (slow_div / 2);
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mclk_code_sync.sv
module mclk_code_sync
    import mclk_pkg::*;
#(
    parameter int W = SEL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1, s2, s3;

    // Two-flop capture; forward only once two samples agree
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            s2 <= s1;
            s3 <= s2;
            if (s2 == s3) q <= s3;
        end
    end
endmodule

// File: rtl/mclk_chan.sv
module mclk_chan
    import mclk_pkg::*;
#(
    parameter logic [7:0] MASK     = 8'b0000_0111,
    parameter int         SLOW_DIV = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_code,
    output logic             clk_o,
    output ratio_e           cur_o,
    output logic             wave_o
);
    localparam int CNT_W = $clog2(SLOW_DIV);

    ratio_e           req;
    ratio_e           cur;
    logic [CNT_W-1:0] cnt;
    logic             wave;
    logic             gate;
    int               per;

    assign req = decode_sel(sel_code, MASK);
    assign per = ratio_period(cur, SLOW_DIV);

    // Divided wave; ratio switch only while the wave is low
    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= RS_STOP;
            cnt  <= '0;
            wave <= 1'b0;
        end else if ((req != cur) && !wave) begin
            cur  <= req;
            cnt  <= '0;
            wave <= 1'b0;
        end else begin
            wave <= ratio_level(cur, int'(cnt), SLOW_DIV);
            if (int'(cnt) >= per - 1) cnt <= '0;
            else                      cnt <= cnt + 1'b1;
        end
    end

    // Pass-through enable changes while the input clock is low
    always_ff @(negedge clk) begin
        if (rst) gate <= 1'b0;
        else     gate <= (cur == RS_FULL);
    end

    assign clk_o  = (clk & gate) | wave;
    assign cur_o  = cur;
    assign wave_o = wave;
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
    import mclk_pkg::*;
#(
    parameter int SLOW_DIV = 512
) (
    input  logic              clk_pri,
    input  logic              clk_sec,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              mclk_a,
    output logic              mclk_b,
    output logic              mclk_c
);
    logic [CTRL_W-1:0] ctrl;
    logic [SEL_W-1:0]  sel_a_sync;
    ratio_e            cur_a, cur_b, cur_c;
    logic              wave_a, wave_b, wave_c;

    always_ff @(posedge clk_pri) begin
        if (rst)        ctrl <= '0;
        else if (wr_en) ctrl <= wr_data;
    end

    mclk_code_sync #(.W(SEL_W)) u_sync_a (
        .clk (clk_sec),
        .rst (rst),
        .d   (ctrl[0*SEL_W +: SEL_W]),
        .q   (sel_a_sync)
    );

    mclk_chan #(.MASK(MASK_A), .SLOW_DIV(SLOW_DIV)) u_chan_a (
        .clk      (clk_sec),
        .rst      (rst),
        .sel_code (sel_a_sync),
        .clk_o    (mclk_a),
        .cur_o    (cur_a),
        .wave_o   (wave_a)
    );

    mclk_chan #(.MASK(MASK_B), .SLOW_DIV(SLOW_DIV)) u_chan_b (
        .clk      (clk_pri),
        .rst      (rst),
        .sel_code (ctrl[1*SEL_W +: SEL_W]),
        .clk_o    (mclk_b),
        .cur_o    (cur_b),
        .wave_o   (wave_b)
    );

    mclk_chan #(.MASK(MASK_C), .SLOW_DIV(SLOW_DIV)) u_chan_c (
        .clk      (clk_pri),
        .rst      (rst),
        .sel_code (ctrl[2*SEL_W +: SEL_W]),
        .clk_o    (mclk_c),
        .cur_o    (cur_c),
        .wave_o   (wave_c)
    );
endmodule

// File: rtl/mclk_gen_chk.sv
module mclk_gen_chk
    import mclk_pkg::*;
(
    input logic   clk_pri,
    input logic   clk_sec,
    input logic   rst,
    input ratio_e cur_a,
    input ratio_e cur_b,
    input ratio_e cur_c,
    input logic   wave_a,
    input logic   wave_b,
    input logic   wave_c
);
    // R10: ratio changes only after a low wave cycle
    p_switch_low_b_r10: assert property (@(posedge clk_pri) disable iff (rst)
        (cur_b != $past(cur_b)) |-> !$past(wave_b));
    p_switch_low_c_r10: assert property (@(posedge clk_pri) disable iff (rst)
        (cur_c != $past(cur_c)) |-> !$past(wave_c));
    p_switch_low_a_r10: assert property (@(posedge clk_sec) disable iff (rst)
        (cur_a != $past(cur_a)) |-> !$past(wave_a));

    // R9: a channel never runs a ratio outside its set
    p_set_a_r9: assert property (@(posedge clk_sec) disable iff (rst)
        (cur_a == RS_STOP) || (cur_a == RS_FULL) || (cur_a == RS_HALF));
    p_set_b_r9: assert property (@(posedge clk_pri) disable iff (rst)
        cur_b != RS_TWO5);
    p_set_c_r9: assert property (@(posedge clk_pri) disable iff (rst)
        cur_c != RS_HALF);

    // R11: stopped or pass-through keeps the divided wave low
    p_stop_low_b_r11: assert property (@(posedge clk_pri) disable iff (rst)
        ((cur_b == RS_STOP) || (cur_b == RS_FULL)) && (cur_b == $past(cur_b))
        |-> !wave_b);
    p_stop_low_c_r11: assert property (@(posedge clk_pri) disable iff (rst)
        ((cur_c == RS_STOP) || (cur_c == RS_FULL)) && (cur_c == $past(cur_c))
        |-> !wave_c);

    // R6: divide-by-5 high phase lasts exactly two cycles
    p_fifth_high_b_r6: assert property (@(posedge clk_pri) disable iff (rst)
        ($rose(wave_b) && cur_b == RS_FIFTH) |=> wave_b ##1 !wave_b);
    p_fifth_high_c_r6: assert property (@(posedge clk_pri) disable iff (rst)
        ($rose(wave_c) && cur_c == RS_FIFTH) |=> wave_c ##1 !wave_c);

    // R7: two-of-five pulses are one cycle wide
    p_two5_pulse_r7: assert property (@(posedge clk_pri) disable iff (rst)
        ($rose(wave_c) && cur_c == RS_TWO5) |=> !wave_c);
endmodule

bind mclk_gen mclk_gen_chk u_mclk_gen_chk (
    .clk_pri (clk_pri),
    .clk_sec (clk_sec),
    .rst     (rst),
    .cur_a   (cur_a),
    .cur_b   (cur_b),
    .cur_c   (cur_c),
    .wave_a  (wave_a),
    .wave_b  (wave_b),
    .wave_c  (wave_c)
);

// File: tb/mclk_gen_bench.sv
module mclk_gen_bench;
    localparam int NS = 1100;

    logic       clk_pri = 1'b0;
    logic       clk_sec = 1'b0;
    logic       rst     = 1'b1;
    logic       wr_en   = 1'b0;
    logic [8:0] wr_data = '0;
    logic       mclk_a, mclk_b, mclk_c;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    bit  hs [NS];
    bit  ls [NS];
    logic [8:0] img = '0;
    int  runt [3];

    always #5 clk_pri = ~clk_pri;
    always #7 clk_sec = ~clk_sec;

    mclk_gen u_mclk_gen (
        .clk_pri (clk_pri),
        .clk_sec (clk_sec),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .mclk_a  (mclk_a),
        .mclk_b  (mclk_b),
        .mclk_c  (mclk_c)
    );

    // R10: minimum phase width monitors
    realtime tr [3] = '{-1.0, -1.0, -1.0};
    realtime tf [3] = '{-1.0, -1.0, -1.0};

    task automatic edge_seen(input int ch, input bit rising);
        realtime lim = (ch == 0) ? 6.0 : 4.0;
        if (rising) begin
            if (!rst && tf[ch] >= 0.0 && ($realtime - tf[ch]) < lim) runt[ch]++;
            tr[ch] = $realtime;
        end else begin
            if (!rst && tr[ch] >= 0.0 && ($realtime - tr[ch]) < lim) runt[ch]++;
            tf[ch] = $realtime;
        end
    endtask

    always @(posedge mclk_a) edge_seen(0, 1'b1);
    always @(negedge mclk_a) edge_seen(0, 1'b0);
    always @(posedge mclk_b) edge_seen(1, 1'b1);
    always @(negedge mclk_b) edge_seen(1, 1'b0);
    always @(posedge mclk_c) edge_seen(2, 1'b1);
    always @(negedge mclk_c) edge_seen(2, 1'b0);

    function automatic bit accepted(input int ch, input int code);
        case (ch)
            0: return code <= 2;
            1: return code <= 3 || code == 5;
            default: return code == 0 || code == 1 || code == 3 || code == 4 || code == 5;
        endcase
    endfunction

    function automatic int period_of(input int mode);
        case (mode)
            2: return 2;
            3: return 5;
            4: return 5;
            default: return 512;
        endcase
    endfunction

    function automatic bit level_of(input int mode, input int ph);
        case (mode)
            2: return ph == 0;
            3: return ph < 2;
            4: return ph == 0 || ph == 2;
            default: return ph < 256;
        endcase
    endfunction

    task automatic settle(input int ch);
        repeat (600) begin
            if (ch == 0) @(posedge clk_sec);
            else         @(posedge clk_pri);
        end
    endtask

    task automatic capture(input int ch);
        for (int i = 0; i < NS; i++) begin
            if (ch == 0) begin
                @(posedge clk_sec); #3; hs[i] = mclk_a; #7; ls[i] = mclk_a;
            end else begin
                @(posedge clk_pri); #2;
                hs[i] = (ch == 1) ? mclk_b : mclk_c; #5;
                ls[i] = (ch == 1) ? mclk_b : mclk_c;
            end
        end
    endtask

    // R2: field write, A in [2:0], B in [5:3], C in [8:6]
    task automatic write_code(input int ch, input int code);
        img[ch*3 +: 3] = 3'(code);
        @(negedge clk_pri);
        wr_en = 1'b1; wr_data = img;
        @(negedge clk_pri);
        wr_en = 1'b0;
    endtask

    task automatic check_chan(input int ch, input int code, input string tag);
        int mode = accepted(ch, code) ? code : 0;
        int miss = 0;
        capture(ch);
        if (mode == 0) begin
            for (int i = 0; i < NS; i++) if (hs[i] || ls[i]) miss++;
        end else if (mode == 1) begin
            for (int i = 0; i < NS; i++) if (!hs[i] || ls[i]) miss++;
        end else begin
            int  per = period_of(mode);
            bit  found = 0;
            for (int i = 0; i < NS; i++) if (hs[i] != ls[i]) miss++;
            for (int o = 0; o < per && !found; o++) begin
                bit m = 1;
                for (int i = 0; i < NS && m; i++)
                    if (hs[i] != level_of(mode, (i + o) % per)) m = 0;
                found = m;
            end
            if (!found) miss++;
        end
        total++;
        if (miss != 0) begin
            bad++;
            $display("FAIL %s ch=%0d code=%0d: mismatches actual=%0d expected=0",
                     tag, ch, code, miss);
        end
    endtask

    function automatic string tag_of(input int ch, input int code);
        if (!accepted(ch, code)) return "R9";
        case (code)
            0: return "R11";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return (ch == 0) ? "R3" : (ch == 1) ? "R4 R2" : "R5";
        endcase
    endfunction

    initial begin
        int codes_a [6] = '{1, 2, 3, 5, 7, 0};
        int codes_b [7] = '{1, 2, 3, 5, 4, 6, 0};
        int codes_c [7] = '{1, 3, 4, 5, 2, 7, 0};
        repeat (6) @(posedge clk_sec);
        @(negedge clk_pri);
        rst = 1'b0;
        // R1: outputs low straight after reset
        for (int ch = 0; ch < 3; ch++) check_chan(ch, 0, "R1");
        foreach (codes_b[k]) begin
            write_code(1, codes_b[k]); settle(1);
            check_chan(1, codes_b[k], tag_of(1, codes_b[k]));
        end
        foreach (codes_c[k]) begin
            write_code(2, codes_c[k]); settle(2);
            check_chan(2, codes_c[k], tag_of(2, codes_c[k]));
        end
        foreach (codes_a[k]) begin
            write_code(0, codes_a[k]); settle(0);
            check_chan(0, codes_a[k], tag_of(0, codes_a[k]));
        end
        // R10: no shortened phase across all switches
        for (int ch = 0; ch < 3; ch++) begin
            total++;
            if (runt[ch] != 0) begin
                bad++;
                $display("FAIL R10 ch=%0d short phases actual=%0d expected=0",
                         ch, runt[ch]);
            end
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule